// File: doc/BRIEF.md
# First-Hit Channel Address Capture

This block watches a bank of 64 per-channel event strobes and reports which channel fired first in an acquisition window. Each channel offers two strobes: one pulses when the input crosses threshold, the other when the peak has been found. A source-select input picks which strobe family takes part. The block masks channels out, then picks a winner in two stages. An OR over each group of eight channels picks the winning group, and a second stage picks the winning channel inside that group. When two or more channels qualify on the same clock edge, the lowest channel number wins.

On the first qualifying edge the block raises a flag and presents a 6-bit channel address. The address is the group index in the upper three bits and the channel-within-group in the lower three bits. While the flag is high, every further strobe is ignored. After a programmable number of cycles the block clears itself and is ready for the next event. The default is 4 cycles, which is 40 ns at 100 MHz. An enable input turns the whole function off. A synchronous acquisition-clear input drops the flag and the address at once.

Top module: `fhit_addr_capture`

## Requirements
- R1: After reset, hit_flag is 0 and hit_addr is 0.
- R2: When the block is armed and enabled and a qualifying strobe is high at a rising clock edge, hit_flag is 1 after that edge and hit_addr holds that channel number.
- R3: When several channels qualify on the same edge, hit_addr is the lowest channel number among them. This also holds when they lie in different groups of eight.
- R4: When src_sel is 0, only thr_hit bits qualify. When src_sel is 1, only pk_hit bits qualify. The other vector has no effect on hit_flag or hit_addr.
- R5: A channel whose mask bit is 1 never qualifies, and a lower masked channel does not hide a higher unmasked one.
- R6: While enable is 0, no capture happens. A 0 on enable at an edge leaves hit_flag at 0 and hit_addr at 0 after that edge.
- R7: hit_flag stays high for exactly HOLD_CYCLES consecutive cycles and then falls. hit_addr is stable while the flag is high and is 0 whenever the flag is low. Strobes that arrive during this interval are ignored.
- R8: After the flag falls, the block is armed again. A strobe that stays high is captured again one cycle after the fall.
- R9: acq_clr high at an edge makes hit_flag 0 and hit_addr 0 after that edge. It takes priority over a capture on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Function enable; 0 holds the block idle |
| acq_clr | input | 1 | Synchronous acquisition clear |
| src_sel | input | 1 | Strobe source: 0 threshold, 1 peak-found |
| thr_hit | input | 64 | Threshold-crossing strobes, bit n is channel n |
| pk_hit | input | 64 | Peak-found strobes, bit n is channel n |
| mask | input | 64 | Channel mask, 1 disables channel n |
| hit_flag | output | 1 | First-hit flag |
| hit_addr | output | 6 | Captured channel number, 0 when idle |

## Verification
Lone hits in both low and high groups show that the group and channel fields are assembled correctly. Simultaneous hits on channels 7 and 8, and on 8, 15 and 63, show whether the lowest-index rule holds across a group boundary or only inside a group. A staggered pair separates a first-come capture from one that is overwritten later in the hold. Strobes on the unselected vector and on masked channels separate correct source selection from a plain OR of both vectors. A strobe held high through two hold periods pins down the exact length of the hold and the one-cycle re-arm gap.

// File: rtl/fhit_pkg.sv
package fhit_pkg;

  typedef enum logic {
    ST_ARMED = 1'b0,
    ST_HOLD  = 1'b1
  } fhit_state_e;

endpackage

// File: rtl/fhit_rst_sync.sv
module fhit_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/fhit_prio_enc.sv
module fhit_prio_enc #(
  parameter int WIDTH = 8,
  localparam int IDX_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] req,
  output logic             valid,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    idx = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx = IDX_W'(i);
      end
    end
  end

  assign valid = |req;

endmodule

// File: rtl/fhit_first_tree.sv
module fhit_first_tree #(
  parameter int N_GROUPS   = 8,
  parameter int GROUP_SIZE = 8,
  localparam int N_CH   = N_GROUPS * GROUP_SIZE,
  localparam int GRP_W  = $clog2(N_GROUPS),
  localparam int CH_W   = $clog2(GROUP_SIZE),
  localparam int ADDR_W = GRP_W + CH_W
) (
  input  logic              src_sel,
  input  logic [N_CH-1:0]   thr_hit,
  input  logic [N_CH-1:0]   pk_hit,
  input  logic [N_CH-1:0]   mask,
  output logic              any_hit,
  output logic [ADDR_W-1:0] first_addr
);

  logic [GROUP_SIZE-1:0] grp_vec [N_GROUPS];
  logic [N_GROUPS-1:0]   grp_any;
  logic [GRP_W-1:0]      grp_idx;
  logic [CH_W-1:0]       ch_idx;
  logic [GROUP_SIZE-1:0] win_vec;
  logic                  ch_valid;

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
    logic [GROUP_SIZE-1:0] src_bits;
    assign src_bits   = src_sel ? pk_hit[g*GROUP_SIZE +: GROUP_SIZE]
                                : thr_hit[g*GROUP_SIZE +: GROUP_SIZE];
    assign grp_vec[g] = src_bits & ~mask[g*GROUP_SIZE +: GROUP_SIZE];
    assign grp_any[g] = |grp_vec[g];
  end

  fhit_prio_enc #(.WIDTH(N_GROUPS)) u_grp_enc (
    .req   (grp_any),
    .valid (any_hit),
    .idx   (grp_idx)
  );

  assign win_vec = grp_vec[grp_idx];

  fhit_prio_enc #(.WIDTH(GROUP_SIZE)) u_ch_enc (
    .req   (win_vec),
    .valid (ch_valid),
    .idx   (ch_idx)
  );

  assign first_addr = ch_valid ? {grp_idx, ch_idx} : '0;

endmodule

// File: rtl/fhit_holdoff.sv
module fhit_holdoff
  import fhit_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int HOLD_CYCLES = 4,
  localparam int CNT_W = $clog2(HOLD_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              acq_clr,
  input  logic              any_hit,
  input  logic [ADDR_W-1:0] first_addr,
  output logic              flag_o,
  output logic [ADDR_W-1:0] addr_o
);

  fhit_state_e       state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              addr_en;
  logic              cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    addr_d  = addr_q;
    addr_en = 1'b0;
    cnt_en  = 1'b0;
    if (acq_clr || !enable) begin
      state_d = ST_ARMED;
      cnt_d   = '0;
      addr_d  = '0;
      addr_en = 1'b1;
      cnt_en  = 1'b1;
    end else begin
      unique case (state_q)
        ST_ARMED: begin
          if (any_hit) begin
            state_d = ST_HOLD;
            cnt_d   = CNT_W'(HOLD_CYCLES - 1);
            addr_d  = first_addr;
            addr_en = 1'b1;
            cnt_en  = 1'b1;
          end
        end
        ST_HOLD: begin
          cnt_en = 1'b1;
          if (cnt_q == '0) begin
            state_d = ST_ARMED;
            addr_d  = '0;
            addr_en = 1'b1;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        default: state_d = ST_ARMED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_ARMED;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end

  assign flag_o = (state_q == ST_HOLD);
  assign addr_o = addr_q;

endmodule

// File: rtl/fhit_addr_capture.sv
module fhit_addr_capture #(
  parameter int N_GROUPS    = 8,
  parameter int GROUP_SIZE  = 8,
  parameter int HOLD_CYCLES = 4,
  parameter int SYNC_STAGES = 2,
  localparam int N_CH   = N_GROUPS * GROUP_SIZE,
  localparam int ADDR_W = $clog2(N_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              acq_clr,
  input  logic              src_sel,
  input  logic [N_CH-1:0]   thr_hit,
  input  logic [N_CH-1:0]   pk_hit,
  input  logic [N_CH-1:0]   mask,
  output logic              hit_flag,
  output logic [ADDR_W-1:0] hit_addr
);

  logic              rst_n_sync;
  logic              any_hit;
  logic [ADDR_W-1:0] first_addr;

  fhit_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_sync)
  );

  fhit_first_tree #(
    .N_GROUPS   (N_GROUPS),
    .GROUP_SIZE (GROUP_SIZE)
  ) u_tree (
    .src_sel    (src_sel),
    .thr_hit    (thr_hit),
    .pk_hit     (pk_hit),
    .mask       (mask),
    .any_hit    (any_hit),
    .first_addr (first_addr)
  );

  fhit_holdoff #(
    .ADDR_W      (ADDR_W),
    .HOLD_CYCLES (HOLD_CYCLES)
  ) u_holdoff (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .enable     (enable),
    .acq_clr    (acq_clr),
    .any_hit    (any_hit),
    .first_addr (first_addr),
    .flag_o     (hit_flag),
    .addr_o     (hit_addr)
  );

endmodule

// File: rtl/fhit_addr_capture_chk.sv
module fhit_addr_capture_chk #(
  parameter int N_CH        = 64,
  parameter int ADDR_W      = 6,
  parameter int HOLD_CYCLES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              acq_clr,
  input logic              src_sel,
  input logic [N_CH-1:0]   thr_hit,
  input logic [N_CH-1:0]   pk_hit,
  input logic [N_CH-1:0]   mask,
  input logic              hit_flag,
  input logic [ADDR_W-1:0] hit_addr
);

  localparam int RUN_W = $clog2(HOLD_CYCLES + 2) + 1;

  logic [N_CH-1:0]  eligible;
  logic [RUN_W-1:0] run_q;

  function automatic logic [ADDR_W-1:0] lowest_idx(input logic [N_CH-1:0] v);
    logic [ADDR_W-1:0] r;
    r = '0;
    for (int i = N_CH - 1; i >= 0; i--) begin
      if (v[i]) r = ADDR_W'(i);
    end
    return r;
  endfunction

  assign eligible = (src_sel ? pk_hit : thr_hit) & ~mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (hit_flag) begin
      run_q <= run_q + 1'b1;
    end else begin
      run_q <= '0;
    end
  end

  AST_FIRST_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hit_flag) |-> (hit_addr == lowest_idx($past(eligible)))); // R3

  AST_RISE_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hit_flag) |-> ($past(eligible) != '0)); // R4

  AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !hit_flag); // R6

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_flag && $past(hit_flag)) |-> $stable(hit_addr)); // R7

  AST_IDLE_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_flag |-> (hit_addr == '0)); // R7

  AST_HOLD_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    hit_flag |-> (run_q < RUN_W'(HOLD_CYCLES))); // R7

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    acq_clr |=> (!hit_flag && hit_addr == '0)); // R9

endmodule

bind fhit_addr_capture fhit_addr_capture_chk #(
  .N_CH        (N_CH),
  .ADDR_W      (ADDR_W),
  .HOLD_CYCLES (HOLD_CYCLES)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .enable   (enable),
  .acq_clr  (acq_clr),
  .src_sel  (src_sel),
  .thr_hit  (thr_hit),
  .pk_hit   (pk_hit),
  .mask     (mask),
  .hit_flag (hit_flag),
  .hit_addr (hit_addr)
);

// File: tb/fhit_addr_capture_tb.sv
module fhit_addr_capture_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HOLD       = 4;

  logic        clk;
  logic        rst_n;
  logic        enable;
  logic        acq_clr;
  logic        src_sel;
  logic [63:0] thr_hit;
  logic [63:0] pk_hit;
  logic [63:0] mask;
  logic        hit_flag;
  logic [5:0]  hit_addr;

  int n_chk;
  int n_fail;
  int exp_q[$];
  bit cut_ok;
  bit prev_flag;
  int run_len;
  bit done;

  fhit_addr_capture #(.HOLD_CYCLES(HOLD)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .acq_clr  (acq_clr),
    .src_sel  (src_sel),
    .thr_hit  (thr_hit),
    .pk_hit   (pk_hit),
    .mask     (mask),
    .hit_flag (hit_flag),
    .hit_addr (hit_addr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [63:0] bit_of(input int n);
    return 64'd1 << n;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (HOLD + 3) @(negedge clk);
  endtask

  // Scoreboard monitor: every rising flag pops one expected address.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (hit_flag && !prev_flag) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected flag", int'(hit_addr), -1);
        end else begin
          int e;
          e = exp_q.pop_front();
          check(hit_addr == 6'(e), "R3 captured address", int'(hit_addr), e);
        end
      end
      if (hit_flag) begin
        run_len++;
      end else begin
        if (run_len > 0 && !cut_ok) begin
          check(run_len == HOLD, "R7 hold length", run_len, HOLD);
        end
        run_len = 0;
      end
      prev_flag = hit_flag;
    end
  end

  // Single capture: strobe for one edge, then release.
  task automatic fire(input logic [63:0] thr, input logic [63:0] pk, input int exp_addr);
    if (exp_addr >= 0) exp_q.push_back(exp_addr);
    thr_hit = thr;
    pk_hit  = pk;
    @(negedge clk);
    thr_hit = '0;
    pk_hit  = '0;
    settle();
  endtask

  initial begin
    rst_n = 1'b0; enable = 1'b0; acq_clr = 1'b0; src_sel = 1'b0;
    thr_hit = '0; pk_hit = '0; mask = '0;
    n_chk = 0; n_fail = 0; cut_ok = 1'b0; prev_flag = 1'b0; run_len = 0; done = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(hit_flag == 1'b0, "R1 flag after reset", int'(hit_flag), 0);
    check(hit_addr == 6'd0, "R1 addr after reset", int'(hit_addr), 0);
    enable = 1'b1;
    @(negedge clk);

    // R2 lone hits, low and high groups
    fire(bit_of(37), '0, 37);
    fire(bit_of(0), '0, 0);
    fire(bit_of(63), '0, 63);

    // R3 simultaneous hits across group boundaries
    fire(bit_of(7) | bit_of(8), '0, 7);
    fire(bit_of(8) | bit_of(15) | bit_of(63), '0, 8);
    fire(bit_of(55) | bit_of(41) | bit_of(49), '0, 41);

    // R7 staggered: later lower hit ignored, address stable
    exp_q.push_back(50);
    thr_hit = bit_of(50);
    @(negedge clk);
    thr_hit = bit_of(50) | bit_of(2);
    @(negedge clk);
    check(hit_addr == 6'd50, "R7 addr held under later hit", int'(hit_addr), 50);
    @(negedge clk);
    check(hit_addr == 6'd50, "R7 addr still held", int'(hit_addr), 50);
    thr_hit = '0;
    settle();
    check(hit_flag == 1'b0 && hit_addr == 6'd0, "R7 idle after hold", int'(hit_addr), 0);

    // R4 source select
    pk_hit = bit_of(3);
    @(negedge clk);
    check(hit_flag == 1'b0, "R4 peak strobe ignored in threshold mode", int'(hit_flag), 0);
    pk_hit = '0;
    settle();
    src_sel = 1'b1;
    fire(bit_of(1), bit_of(3), 3);
    fire(bit_of(30), bit_of(60) | bit_of(12), 12);
    src_sel = 1'b0;

    // R5 masking
    mask = bit_of(0) | bit_of(16);
    fire(bit_of(0) | bit_of(16) | bit_of(20), '0, 20);
    thr_hit = bit_of(0);
    @(negedge clk);
    check(hit_flag == 1'b0, "R5 masked-only hit ignored", int'(hit_flag), 0);
    thr_hit = '0;
    mask = '0;
    settle();

    // R6 enable
    enable = 1'b0;
    thr_hit = bit_of(9);
    @(negedge clk);
    check(hit_flag == 1'b0, "R6 no capture while disabled", int'(hit_flag), 0);
    thr_hit = '0;
    enable = 1'b1;
    settle();
    exp_q.push_back(5);
    thr_hit = bit_of(5);
    @(negedge clk);
    thr_hit = '0;
    @(negedge clk);
    cut_ok = 1'b1;
    enable = 1'b0;
    @(negedge clk);
    check(hit_flag == 1'b0 && hit_addr == 6'd0, "R6 disable drops flag", int'(hit_flag), 0);
    enable = 1'b1;
    settle();
    cut_ok = 1'b0;

    // R9 acquisition clear
    exp_q.push_back(33);
    thr_hit = bit_of(33);
    @(negedge clk);
    thr_hit = '0;
    cut_ok = 1'b1;
    acq_clr = 1'b1;
    @(negedge clk);
    check(hit_flag == 1'b0 && hit_addr == 6'd0, "R9 clear drops flag", int'(hit_addr), 0);
    thr_hit = bit_of(9);
    @(negedge clk);
    check(hit_flag == 1'b0, "R9 clear beats capture", int'(hit_flag), 0);
    thr_hit = '0;
    acq_clr = 1'b0;
    settle();
    cut_ok = 1'b0;

    // R8 re-arm with a strobe held high
    exp_q.push_back(12);
    exp_q.push_back(12);
    thr_hit = bit_of(12);
    repeat (HOLD + 1) @(negedge clk);
    check(hit_flag == 1'b0, "R8 one-cycle gap after hold", int'(hit_flag), 0);
    @(negedge clk);
    check(hit_flag == 1'b1 && hit_addr == 6'd12, "R8 recapture", int'(hit_addr), 12);
    thr_hit = '0;
    settle();

    check(exp_q.size() == 0, "R2 all expected captures seen", exp_q.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule